// File: doc/BRIEF.md
# Frame Step Interrupt Generator

This block counts CPU clock cycles from the most recent control write and marks the steps of a frame. At three quarter points it pulses a quarter-frame strobe, which the envelope and linear-counter units use. At the half point it also pulses a half-frame strobe for the length and sweep units. At the final step of the frame it pulses both strobes and raises a frame interrupt. After the final step the count wraps, so the frame repeats for as long as no new control write arrives.

The interrupt is reported in two ways. A readable status flag is driven on three consecutive cycles at the end of each frame. A separate active-low request line goes low only on the last of those three cycles, two clocks after the flag first rises. Software acknowledges the interrupt by reading the status, which clears both the flag and the request. A bit in the control byte inhibits the interrupt completely. The count restarts one clock after a control write. Until then the old count keeps running, so a step that falls due in that window still fires on time.

Top module: `frame_irq_gen`

## Requirements
- R1: While reset is held, and on the first cycle after it, `status_flag` is 0, `irq_n` is 1, and both strobes are 0.
- R2: After a control write sampled on clock edge e0 with bit 6 clear, `status_flag` reads 0 up to edge e0+FLAG_CYC-1 and reads 1 after edge e0+FLAG_CYC.
- R3: The flag is set on three consecutive edges, e0+FLAG_CYC through e0+FLAG_CYC+2. A status read that takes effect on any of those edges leaves the flag at 1.
- R4: `irq_n` stays 1 after edge e0+FLAG_CYC+1 and goes to 0 after edge e0+FLAG_CYC+2. Whenever `irq_n` is 0, the flag is 1.
- R5: `qtr_stb` is a one-cycle pulse after edges e0+QTR1, e0+QTR2, e0+QTR3 and e0+FLAG_CYC+2, and is 0 on all other cycles of the frame.
- R6: `half_stb` is a one-cycle pulse after edges e0+QTR2 and e0+FLAG_CYC+2 only, and it is only ever high together with `qtr_stb`.
- R7: Without a new write, the whole step pattern repeats with a period of FLAG_CYC+1 cycles.
- R8: A status read (`rd_ack` high for one cycle) on an edge outside the three set edges clears `status_flag` to 0 and returns `irq_n` to 1 after that edge.
- R9: A control write with bit 6 (the inhibit bit) set clears the flag and releases `irq_n` after edge e0+1. While inhibit is held, the flag stays 0 and `irq_n` stays 1, even across frame ends.
- R10: A control write restarts the count on the clock that follows the write edge. A step that falls due on the write edge or on the next edge is still issued from the old count.
- R11: Once low, `irq_n` stays low until a status read or an inhibit write releases it, across later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle control write strobe |
| wr_data | input | DW | Control byte; bit 6 is the inhibit bit |
| rd_ack | input | 1 | Single-cycle status read; clears the flag |
| status_flag | output | 1 | Readable frame interrupt flag |
| irq_n | output | 1 | Active-low interrupt request |
| qtr_stb | output | 1 | Quarter-frame clock strobe |
| half_stb | output | 1 | Half-frame clock strobe |

## Verification
The bench builds the block with FLAG_CYC=13 and quarter steps at 3, 6 and 10, which gives a frame of 14 cycles. With this size, every cycle of several frames is compared against the expected output. A status read is swept across every phase of the frame, so each of the three set edges and every clearing edge is hit. The short frame also makes it practical to place a restart exactly where an old step falls due on the edge after the write.

// File: rtl/frame_irq_pkg.sv
package frame_irq_pkg;
  // Decoded conditions of the current count, before registering.
  typedef struct packed {
    logic qtr;      // quarter-frame step due on the next edge
    logic half;     // half-frame step due on the next edge
    logic flag_set; // inside the three-edge flag window
    logic irq_hit;  // last edge of the window: request fires
  } step_t;

  localparam int unsigned NUM_QTR = 3;
  localparam int unsigned HALF_IDX = 1; // which quarter point also clocks half
endpackage

// File: rtl/fseq_counter.sv
module fseq_counter #(
  parameter int unsigned LAST = 29831,
  parameter int unsigned CW   = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_inh,
  output logic [CW-1:0] cnt,
  output logic          eff_inh
);
  logic restart_q;
  logic pend_inh_q;
  logic inh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      restart_q  <= 1'b0;
      pend_inh_q <= 1'b0;
      inh_q      <= 1'b0;
      cnt        <= '0;
    end else begin
      restart_q <= wr_en;
      if (wr_en) pend_inh_q <= wr_inh;
      if (restart_q) begin
        cnt   <= '0;
        inh_q <= pend_inh_q;
      end else if (cnt == CW'(LAST)) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // The inhibit bit takes hold on the same edge as the restart.
  assign eff_inh = restart_q ? pend_inh_q : inh_q;
endmodule

// File: rtl/fseq_step_dec.sv
module fseq_step_dec
  import frame_irq_pkg::*;
#(
  parameter int unsigned LAST = 29831,
  parameter int unsigned CW   = 15,
  parameter int unsigned QTR1 = 7457,
  parameter int unsigned QTR2 = 14913,
  parameter int unsigned QTR3 = 22371
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  output step_t         step,
  output logic          qtr_stb,
  output logic          half_stb
);
  localparam int unsigned QPOS [NUM_QTR] = '{QTR1, QTR2, QTR3};
  localparam int unsigned WIN_LO = LAST - 2;

  logic [NUM_QTR-1:0] qmatch;

  // Step times are counted from the write edge; the count starts one
  // edge later and the strobe register adds one more.
  for (genvar g = 0; g < NUM_QTR; g++) begin : g_qpos
    assign qmatch[g] = (cnt == CW'(QPOS[g] - 2));
  end

  logic final_step;
  assign final_step = (cnt == CW'(LAST));

  always_comb begin
    step.qtr      = (|qmatch) | final_step;
    step.half     = qmatch[HALF_IDX] | final_step;
    step.flag_set = (cnt >= CW'(WIN_LO));
    step.irq_hit  = final_step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qtr_stb  <= 1'b0;
      half_stb <= 1'b0;
    end else begin
      qtr_stb  <= step.qtr;
      half_stb <= step.half;
    end
  end
endmodule

// File: rtl/fseq_irq_state.sv
module fseq_irq_state (
  input  logic clk,
  input  logic rst,
  input  logic eff_inh,
  input  logic flag_set,
  input  logic irq_hit,
  input  logic rd_ack,
  output logic status_flag,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status_flag <= 1'b0;
      irq_n       <= 1'b1;
    end else if (eff_inh) begin
      status_flag <= 1'b0;
      irq_n       <= 1'b1;
    end else begin
      // A set in the same clock outranks the read clear.
      if (flag_set)    status_flag <= 1'b1;
      else if (rd_ack) status_flag <= 1'b0;
      if (irq_hit)     irq_n <= 1'b0;
      else if (rd_ack) irq_n <= 1'b1;
    end
  end
endmodule

// File: rtl/frame_irq_gen.sv
module frame_irq_gen
  import frame_irq_pkg::*;
#(
  parameter int unsigned FLAG_CYC = 29831,
  parameter int unsigned QTR1     = 7457,
  parameter int unsigned QTR2     = 14913,
  parameter int unsigned QTR3     = 22371,
  parameter int unsigned DW       = 8,
  parameter int unsigned INH_BIT  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_ack,
  output logic          status_flag,
  output logic          irq_n,
  output logic          qtr_stb,
  output logic          half_stb
);
  localparam int unsigned CW = $clog2(FLAG_CYC + 1);

  logic [CW-1:0] cnt;
  logic          eff_inh;
  step_t         step;

  fseq_counter #(.LAST(FLAG_CYC), .CW(CW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_inh  (wr_data[INH_BIT]),
    .cnt     (cnt),
    .eff_inh (eff_inh)
  );

  fseq_step_dec #(
    .LAST(FLAG_CYC), .CW(CW), .QTR1(QTR1), .QTR2(QTR2), .QTR3(QTR3)
  ) u_dec (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt),
    .step     (step),
    .qtr_stb  (qtr_stb),
    .half_stb (half_stb)
  );

  fseq_irq_state u_irq (
    .clk         (clk),
    .rst         (rst),
    .eff_inh     (eff_inh),
    .flag_set    (step.flag_set),
    .irq_hit     (step.irq_hit),
    .rd_ack      (rd_ack),
    .status_flag (status_flag),
    .irq_n       (irq_n)
  );
endmodule

// File: rtl/frame_irq_chk.sv
module frame_irq_chk #(
  parameter int unsigned DW      = 8,
  parameter int unsigned INH_BIT = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          rd_ack,
  input logic          status_flag,
  input logic          irq_n,
  input logic          qtr_stb,
  input logic          half_stb
);
  logic wr_seen, wr_bit, inh_trk;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_seen <= 1'b0;
      wr_bit  <= 1'b0;
      inh_trk <= 1'b0;
    end else begin
      wr_seen <= wr_en;
      if (wr_en) wr_bit <= wr_data[INH_BIT];
      if (wr_seen) inh_trk <= wr_bit;
    end
  end

  assert_req_needs_flag_R4: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> status_flag);

  assert_req_lags_flag_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> ($past(status_flag, 1) && $past(status_flag, 2)));

  assert_qtr_single_R5: assert property (@(posedge clk) disable iff (rst)
    qtr_stb |=> !qtr_stb);

  assert_half_with_qtr_R6: assert property (@(posedge clk) disable iff (rst)
    half_stb |-> qtr_stb);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(status_flag) |-> ($past(rd_ack) || inh_trk));

  assert_inhibit_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    inh_trk |-> (!status_flag && irq_n));

  assert_req_holds_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_n) |-> ($past(rd_ack) || inh_trk));
endmodule

bind frame_irq_gen frame_irq_chk #(.DW(DW), .INH_BIT(INH_BIT)) u_chk (.*);

// File: tb/sim_frame_irq_gen.sv
`timescale 1ns/1ps
module sim_frame_irq_gen;
  localparam int FLAG = 13;
  localparam int Q1 = 3, Q2 = 6, Q3 = 10;
  localparam int P = FLAG + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic rd_ack = 1'b0;
  logic status_flag, irq_n, qtr_stb, half_stb;

  always #5 clk = ~clk;

  frame_irq_gen #(.FLAG_CYC(FLAG), .QTR1(Q1), .QTR2(Q2), .QTR3(Q3)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_ack(rd_ack),
    .status_flag(status_flag), .irq_n(irq_n), .qtr_stb(qtr_stb), .half_stb(half_stb)
  );

  int checks = 0;
  int errors = 0;
  int k = 0;
  logic inh = 1'b0, pinh = 1'b0, mflag = 1'b0, mirq = 1'b1;

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at k=%0d got %0b expected %0b", tag, k, got, exp);
    end
  endtask

  // Drive one control write; the posedge after this call is edge e0.
  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    pinh = d[6];
    k = 0;
  endtask

  // Advance one edge with an optional read and compare every output.
  task automatic cyc(input logic rd);
    int kn, c;
    logic set, hit, eq, eh, chkstb;
    kn = k + 1; rd_ack = rd;
    set = 1'b0; hit = 1'b0; eq = 1'b0; eh = 1'b0; chkstb = 1'b0;
    if (kn == 1) begin
      inh = pinh;
    end else begin
      c = (kn - 2) % P;
      set = !inh && (c >= FLAG - 2);
      hit = !inh && (c == FLAG);
      eq = (c == Q1 - 2) || (c == Q2 - 2) || (c == Q3 - 2) || (c == FLAG);
      eh = (c == Q2 - 2) || (c == FLAG);
      chkstb = 1'b1;
    end
    if (inh) begin
      mflag = 1'b0; mirq = 1'b1;
    end else begin
      if (set) mflag = 1'b1; else if (rd) mflag = 1'b0;
      if (hit) mirq = 1'b0; else if (rd) mirq = 1'b1;
    end
    @(negedge clk);
    rd_ack = 1'b0;
    k = kn;
    chk("R3", status_flag, mflag);
    chk("R4", irq_n, mirq);
    if (chkstb) begin
      chk("R5", qtr_stb, eq);
      chk("R6", half_stb, eh);
    end
  endtask

  // Inhibit write, then a plain write from a small old count.
  task automatic clean_start();
    wr(8'h40);
    cyc(1'b0); cyc(1'b0);
    wr(8'h00);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", status_flag, 1'b0);
    chk("R1", irq_n, 1'b1);
    chk("R1", qtr_stb, 1'b0);
    chk("R1", half_stb, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", status_flag, 1'b0);
    chk("R1", irq_n, 1'b1);

    // Three full frames with no reads.
    wr(8'h00);
    for (int i = 0; i < 3 * P; i++) begin
      cyc(1'b0);
      if (k == FLAG - 1) chk("R2", status_flag, 1'b0);
      if (k == FLAG) chk("R2", status_flag, 1'b1);
      if (k == FLAG + 1) chk("R4", irq_n, 1'b1);
      if (k == FLAG + 2) chk("R4", irq_n, 1'b0);
      if (k == Q2 + P || k == Q2 + 2 * P) chk("R7", half_stb, 1'b1);
      if (k == FLAG + 2 + P) chk("R7", qtr_stb, 1'b1);
    end
    chk("R11", irq_n, 1'b0);

    // Status read swept over every phase of the second frame.
    for (int rp = 0; rp < P; rp++) begin
      clean_start();
      while (k < P + 1 + rp) cyc(1'b0);
      cyc(1'b1);
      if (rp < FLAG - 2) begin
        chk("R8", status_flag, 1'b0);
        chk("R8", irq_n, 1'b1);
      end else begin
        chk("R3", status_flag, 1'b1);
      end
      if (rp == FLAG) chk("R4", irq_n, 1'b0);
      cyc(1'b0); cyc(1'b0);
    end

    // Inhibit while the interrupt is pending, then hold it across frames.
    clean_start();
    while (k < FLAG + 2) cyc(1'b0);
    wr(8'h40);
    cyc(1'b0);
    chk("R9", status_flag, 1'b0);
    chk("R9", irq_n, 1'b1);
    for (int i = 0; i < 2 * P; i++) cyc(1'b0);
    chk("R9", status_flag, 1'b0);
    chk("R9", irq_n, 1'b1);

    // Restart with an old half-frame step due on the edge after the write.
    clean_start();
    while (k < 4) cyc(1'b0);
    wr(8'h00);
    cyc(1'b0);
    chk("R10", qtr_stb, 1'b1);
    chk("R10", half_stb, 1'b1);
    while (k < FLAG - 1) cyc(1'b0);
    chk("R10", status_flag, 1'b0);
    cyc(1'b0);
    chk("R10", status_flag, 1'b1);
    while (k < FLAG + 2 + 2 * P) cyc(1'b0);
    chk("R11", irq_n, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule